// File: doc/BRIEF.md
# Interleaved Line-Fill Engine

This block answers cache-line fill requests from a group of interleaved memory banks that share one narrow return bus. A requester presents a line address while the engine is ready. The engine spends one bus cycle on the address and starts every bank reading its share of the line at the same moment. Each bank has a fixed, modelled access latency. Once every bank has its word, the engine streams the line back one word per cycle. Words come out in ascending offset order, and a flag marks the final word.

Words are placed across banks by a rehash. The bank that holds a word is its offset XOR the most significant bank-index-width bits of the line address, which form the tag part. Two lines that differ only in tag therefore place the same offset in different banks. A separate load port writes single words into the bank storage, using the same placement.

A fill always occupies a fixed number of cycles: one address cycle, then the access latency, then one cycle per bank. Default sizes are a 6-bit line address, 4 banks, a 15-cycle latency and 32-bit words, which give 20 cycles per fill.

Top module: `ilv_fill_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `resp_last` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The cycle after that edge is the address cycle, in which `resp_valid` and `req_ready` are both 0.
- R3: Count the address cycle as cycle 1. The words of the line then occupy cycles LATENCY+2 through LATENCY+NUM_BANKS+1. Between the address cycle and the first word, `resp_valid` stays 0.
- R4: Words come out on consecutive cycles with `resp_offset` equal to 0, 1, ..., NUM_BANKS-1, in that order.
- R5: `resp_last` is 1 only on the word whose offset is NUM_BANKS-1.
- R6: `resp_bank` reports the bank that supplied the current word. For word offset w of line L, that bank is w XOR L[LINE_W-1 -: BANK_W].
- R7: `resp_data` for offset w of line L is the last word loaded for (L, w) before or together with the clock edge that ends the address cycle. Loads after that edge do not change the line in flight, and a load on that same edge is not seen by it.
- R8: A load (`ld_en` = 1) writes `ld_data` for word `ld_offset` of line `ld_line` into bank `ld_offset` XOR `ld_line`[LINE_W-1 -: BANK_W] at row `ld_line`. A load is accepted in any cycle.
- R9: `req_valid` is ignored while `req_ready` is 0. A request raised and dropped during a fill starts no second fill and does not disturb the words of the current one.
- R10: `req_ready` returns to 1 in the cycle of the last word. A request accepted at the edge that ends that cycle has its address cycle immediately after it, so back-to-back fills start every 1+LATENCY+NUM_BANKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_line | input | LINE_W | Line address of the request |
| req_ready | output | 1 | Engine can accept a request this cycle |
| resp_valid | output | 1 | A word of the line is on the bus |
| resp_data | output | DATA_W | Returned word |
| resp_offset | output | BANK_W | Offset of the returned word within its line |
| resp_bank | output | BANK_W | Bank that supplied the returned word |
| resp_last | output | 1 | Final word of the line |
| ld_en | input | 1 | Write one word into bank storage |
| ld_line | input | LINE_W | Line address of the word to write |
| ld_offset | input | BANK_W | Word offset of the word to write |
| ld_data | input | DATA_W | Word to write |

## Verification
Isolated fills at the extremes of the line space separate the rehash from a plain offset-to-bank mapping. Line 0 leaves the mapping unchanged, while lines with tag 1 and tag 3 permute the banks. Chained fills, issued in the cycle of the last word, show whether the fill period is exactly 1+LATENCY+NUM_BANKS or one cycle longer. Two kinds of stimulus target a busy engine: requests raised during the access wait, and loads on the read edge or later in the wait. These separate a design that snapshots the line when its read starts from one that restarts, or that reads late. Random lines, chaining and these disturbances are mixed to cover further combinations.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER
  } fill_state_e;
endpackage

// File: rtl/fill_bank.sv
// One memory bank: synchronous array, read sampled at start, data ready after LATENCY cycles.
module fill_bank #(
  parameter int ROW_W   = 6,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_start,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ok
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  wait_cnt;
  logic              armed;

  // read-before-write on a shared edge: the read sees the old word
  always_ff @(posedge clk) begin
    if (rd_start) rd_data <= mem[rd_row];
    if (wr_en)    mem[wr_row] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      wait_cnt <= '0;
    end else if (rd_start) begin
      armed    <= 1'b1;
      wait_cnt <= CNT_W'(LATENCY - 1);
    end else if (armed && wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign rd_ok = armed && (wait_cnt == '0);
endmodule

// File: rtl/fill_seq.sv
// Fill sequencer: address cycle, access wait, word streaming.
module fill_seq
  import fill_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              all_ok,
  output logic              accept,
  output logic              ready,
  output logic              bank_start,
  output logic              xfer,
  output logic [BANK_W-1:0] word_idx,
  output logic              last_word
);
  fill_state_e state;

  assign xfer       = (state == ST_XFER);
  assign last_word  = xfer && (word_idx == BANK_W'(NUM_BANKS - 1));
  assign ready      = (state == ST_IDLE) || last_word;
  assign accept     = req_valid && ready;
  assign bank_start = (state == ST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= ST_ADDR;
        ST_ADDR: state <= ST_WAIT;
        ST_WAIT: if (all_ok) begin
          state    <= ST_XFER;
          word_idx <= '0;
        end
        ST_XFER: begin
          word_idx <= word_idx + 1'b1;
          if (last_word) state <= accept ? ST_ADDR : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_fill_engine.sv
// Interleaved line-fill engine with XOR bank rehash.
module ilv_fill_engine #(
  parameter int DATA_W    = 32,
  parameter int LINE_W    = 6,
  parameter int NUM_BANKS = 4,
  parameter int LATENCY   = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [LINE_W-1:0]            req_line,
  output logic                         req_ready,
  output logic                         resp_valid,
  output logic [DATA_W-1:0]            resp_data,
  output logic [$clog2(NUM_BANKS)-1:0] resp_offset,
  output logic [$clog2(NUM_BANKS)-1:0] resp_bank,
  output logic                         resp_last,
  input  logic                         ld_en,
  input  logic [LINE_W-1:0]            ld_line,
  input  logic [$clog2(NUM_BANKS)-1:0] ld_offset,
  input  logic [DATA_W-1:0]            ld_data
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  // bank holding word 'off' of line 'line': offset XOR upper tag bits
  function automatic logic [BANK_W-1:0] bank_of(input logic [LINE_W-1:0] line,
                                                input logic [BANK_W-1:0] off);
    return off ^ line[LINE_W-1 -: BANK_W];
  endfunction

  logic                accept;
  logic                bank_start;
  logic                xfer;
  logic                last_word;
  logic [BANK_W-1:0]   word_idx;
  logic [LINE_W-1:0]   line_q;
  logic [NUM_BANKS-1:0] bank_ok;
  logic                all_ok;
  logic                any_ok;
  logic [BANK_W-1:0]   ld_bank;
  logic [DATA_W-1:0]   bank_rd [NUM_BANKS];

  assign ld_bank = bank_of(ld_line, ld_offset);
  assign all_ok  = &bank_ok;
  assign any_ok  = |bank_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)      line_q <= '0;
    else if (accept) line_q <= req_line;
  end

  fill_seq #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .all_ok    (all_ok),
    .accept    (accept),
    .ready     (req_ready),
    .bank_start(bank_start),
    .xfer      (xfer),
    .word_idx  (word_idx),
    .last_word (last_word)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fill_bank #(
      .ROW_W  (LINE_W),
      .DATA_W (DATA_W),
      .LATENCY(LATENCY)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ld_en && (ld_bank == BANK_W'(b))),
      .wr_row  (ld_line),
      .wr_data (ld_data),
      .rd_start(bank_start),
      .rd_row  (line_q),
      .rd_data (bank_rd[b]),
      .rd_ok   (bank_ok[b])
    );
  end

  assign resp_valid  = xfer;
  assign resp_offset = word_idx;
  assign resp_bank   = bank_of(line_q, word_idx);
  assign resp_data   = bank_rd[resp_bank];
  assign resp_last   = last_word;
endmodule

// File: rtl/fill_engine_chk.sv
// Temporal checks for ilv_fill_engine.
module fill_engine_chk #(
  parameter int NUM_BANKS = 4,
  parameter int LATENCY   = 15,
  parameter int BANK_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_last,
  input logic [BANK_W-1:0] resp_offset,
  input logic              all_ok,
  input logic              any_ok
);
  logic [15:0] since_req;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_req <= '0;
    else if (accept)           since_req <= 16'd1;
    else if (since_req != '0 && since_req != 16'hffff) since_req <= since_req + 16'd1;
  end

  // R2
  addr_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!resp_valid && !req_ready));

  // R3
  first_word_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_offset == '0) |-> since_req == 16'(LATENCY + 2));

  // R3
  last_word_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last |-> since_req == 16'(LATENCY + NUM_BANKS + 1));

  // R3
  banks_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_ok |-> all_ok);

  // R4
  offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_last) |=>
      (resp_valid && resp_offset == BANK_W'($past(resp_offset) + 1'b1)));

  // R5
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last |-> (resp_valid && resp_offset == BANK_W'(NUM_BANKS - 1)));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_last) |-> !req_ready);
endmodule

bind ilv_fill_engine fill_engine_chk #(
  .NUM_BANKS(NUM_BANKS),
  .LATENCY  (LATENCY),
  .BANK_W   (BANK_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_last  (resp_last),
  .resp_offset(resp_offset),
  .all_ok     (all_ok),
  .any_ok     (any_ok)
);

// File: tb/test_ilv_fill_engine.sv
module test_ilv_fill_engine;
  localparam int DW  = 32;
  localparam int LW  = 6;
  localparam int NB  = 4;
  localparam int LAT = 15;
  localparam int NL  = 1 << LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic          req_ready;
  logic          resp_valid;
  logic [DW-1:0] resp_data;
  logic [1:0]    resp_offset;
  logic [1:0]    resp_bank;
  logic          resp_last;
  logic          ld_en = 1'b0;
  logic [LW-1:0] ld_line = '0;
  logic [1:0]    ld_offset = '0;
  logic [DW-1:0] ld_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] model [NL*NB];

  always #2.5 clk = ~clk;

  ilv_fill_engine #(.DATA_W(DW), .LINE_W(LW), .NUM_BANKS(NB), .LATENCY(LAT)) i_ilv_fill_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_offset(resp_offset), .resp_bank(resp_bank), .resp_last(resp_last),
    .ld_en(ld_en), .ld_line(ld_line), .ld_offset(ld_offset), .ld_data(ld_data));

  // expected bank: the tag is the line divided by 2^(LW-2), combined bitwise-exclusive with the offset
  function automatic int exp_bank(input int line, input int off);
    int tag = line / (NL / NB);
    return (off | tag) & ~(off & tag) & (NB - 1);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  // R8: single word load through the load port (starts and ends at a negedge)
  task automatic do_load(input int line, input int off, input logic [DW-1:0] d);
    ld_en = 1'b1; ld_line = LW'(line); ld_offset = 2'(off); ld_data = d;
    model[line*NB+off] = d;
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
  endtask

  // mode: 0 plain, 1 request poked while busy, 2 load on read edge, 3 load during wait
  task automatic run_fill(input int line, input bit chained, input int next_line, input int mode);
    logic [DW-1:0] snap [NB];
    for (int o = 0; o < NB; o++) snap[o] = model[line*NB+o];
    if (!chained) begin
      check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
      req_valid = 1'b1; req_line = LW'(line);
    end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(!resp_valid && !req_ready, "R2", "address cycle valid/ready",
          {resp_valid, req_ready}, 0);
    if (mode == 2) begin
      int o2 = $urandom % NB;
      logic [DW-1:0] d2 = $urandom;
      ld_en = 1'b1; ld_line = LW'(line); ld_offset = 2'(o2); ld_data = d2;
      model[line*NB+o2] = d2;
    end
    for (int k = 1; k <= LAT + NB; k++) begin
      int w;
      @(posedge clk); @(negedge clk);
      ld_en = 1'b0;
      if (mode == 3 && k == 3) begin
        int o3 = $urandom % NB;
        logic [DW-1:0] d3 = ~snap[o3];
        ld_en = 1'b1; ld_line = LW'(line); ld_offset = 2'(o3); ld_data = d3;
        model[line*NB+o3] = d3;
      end
      if (mode == 1) begin
        if (k == 2) begin req_valid = 1'b1; req_line = LW'(line ^ 1); end
        if (k == LAT) req_valid = 1'b0;
      end
      w = k - (LAT + 1);
      if (w < 0) begin
        check(!resp_valid && !req_ready, "R3", "no word during access wait",
              {resp_valid, req_ready}, 0);
      end else begin
        check(resp_valid == 1'b1, "R3", "word present", resp_valid, 1);
        check(int'(resp_offset) == w, "R4", "word offset", resp_offset, w);
        check(int'(resp_bank) == exp_bank(line, w), "R6", "source bank",
              resp_bank, exp_bank(line, w));
        check(resp_data == snap[w], "R7", "word data", resp_data, snap[w]);
        check(resp_last == (w == NB - 1), "R5", "last flag", resp_last, w == NB - 1);
        check(req_ready == (w == NB - 1), "R10", "ready on last word", req_ready, w == NB - 1);
        if (w == NB - 1 && next_line >= 0) begin
          req_valid = 1'b1; req_line = LW'(next_line);
        end
      end
    end
    if (next_line < 0) begin
      for (int q = 0; q < 3; q++) begin
        @(posedge clk); @(negedge clk);
        check(!resp_valid && req_ready, "R9", "idle after fill, no extra fill",
              {resp_valid, req_ready}, 1);
      end
    end
  endtask

  initial begin
    int pend;
    void'($urandom(32'h1c0ffee));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    check(!resp_valid && !resp_last, "R1", "no response in reset", {resp_valid, resp_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !resp_valid, "R1", "state after reset", {req_ready, resp_valid}, 2);

    for (int l = 0; l < NL; l++)
      for (int o = 0; o < NB; o++) do_load(l, o, $urandom);

    // directed: tag 0, tag 3, tag 1 lines
    run_fill(0, 0, -1, 0);
    run_fill(NL - 1, 0, -1, 0);
    run_fill(NL / NB, 0, -1, 0);
    // R8: reload one line and read it back
    for (int o = 0; o < NB; o++) do_load(37, o, 32'hA5000000 + o);
    run_fill(37, 0, -1, 0);
    // R10: back-to-back chain, same row different tags
    run_fill(5, 0, 5 + NL / 2, 0);
    run_fill(5 + NL / 2, 1, 21, 0);
    run_fill(21, 1, -1, 0);
    // R9 and R7 corner cases
    run_fill(12, 0, -1, 1);
    run_fill(44, 0, -1, 2);
    run_fill(44, 0, -1, 0);
    run_fill(60, 0, -1, 3);

    pend = -1;
    for (int i = 0; i < 40; i++) begin
      int line = (pend >= 0) ? pend : int'($urandom % NL);
      int nxt = (i < 39 && ($urandom % 2) == 1) ? int'($urandom % NL) : -1;
      int mode = $urandom % 4;
      if ($urandom % 4 == 0 && pend < 0) do_load(line, $urandom % NB, $urandom);
      run_fill(line, pend >= 0, nxt, mode);
      pend = nxt;
    end
    finish_run();
  end
endmodule